// File: doc/BRIEF.md
# I2C Slave Clock Stretch Controller

This block decides when an I2C / SMBus-style slave may hold the SCL line low to buy time for its core logic. It watches the bus lines through a two-flop synchronizer. From them it finds START and STOP conditions and counts the clock pulses of each byte. It allows a stretch at only two points: the SCL low phase that follows a START, and the SCL low phase that follows the ninth (acknowledge) clock of a byte. The block never makes a clock edge. It can only pull SCL low, through an open-drain enable, or let it go.

A stretch starts once the slave core raises `busy` inside an allowed low phase and a short hold delay has passed. The delay length depends on the bus rate: standard mode (100 kHz) or fast mode (400 kHz). The rate is taken only while the bus is idle, and it is standard mode after reset. The stretch ends when `busy` drops. A hard cap ends it in any case: after a set number of system clock cycles, computed from the clock frequency and a limit in microseconds (25 ms by default), SCL is released and a one-cycle timeout pulse is given.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `scl_pull` and `stretch_timeout` are 0.
- R2: During clock pulses 1 to 8 of a byte, `scl_pull` stays 0 even when `busy` is 1.
- R3: When `busy` is 1 in the low phase after the ninth clock, `scl_pull` rises. It stays 1 while `busy` stays 1, and falls at the first clock edge that samples `busy` at 0.
- R4: The SCL low phase that directly follows a START (first or repeated) is also a legal stretch point.
- R5: A stretch lasts at most TMAX = (CLK_HZ/1e6)*STRETCH_US cycles. At that point `scl_pull` falls even though `busy` is still 1, and `stretch_timeout` is 1 for exactly that one cycle.
- R6: After a stretch ends, by release or by timeout, no new stretch starts until the next legal point.
- R7: `scl_pull` rises at the (D+4)th rising clock edge after `scl_in` falls at a legal point. D is DLY_SLOW when `rate_fast` is 0 (standard mode) and DLY_FAST when it is 1 (fast mode).
- R8: The rate is taken from `rate_fast` only while no transfer is open, between a STOP (or reset) and a START. A change during a transfer has no effect until after the STOP. After reset the rate is standard mode.
- R9: A repeated START or a STOP clears the clock count and cancels any open stretch window. After a STOP, `busy` alone never causes a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| busy | input | 1 | Slave core requests extra time |
| rate_fast | input | 1 | 0 = standard mode, 1 = fast mode |
| scl_pull | output | 1 | Open-drain enable, 1 pulls SCL low |
| stretch_timeout | output | 1 | One-cycle pulse when the stretch cap expires |

## Verification
A falling SCL at a legal point shows on `scl_pull` D+4 edges later: two synchronizer stages, one window register, then D+1 count steps. The bench therefore samples at negative edges exactly D+3 and D+4 edges after it drives SCL low, and expects 0 and then 1. `busy` is not synchronized, so a release is checked one edge after `busy` falls. The timeout is checked TMAX-1 and TMAX edges after the stretch appears, with the pulse expected on the release sample and gone on the next.

// File: rtl/i2c_stretch_ctrl.sv
`timescale 1ns/1ps
module i2c_stretch_ctrl #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int STRETCH_US = 25_000,
  parameter int DLY_SLOW   = 20,
  parameter int DLY_FAST   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic busy,
  input  logic rate_fast,
  output logic scl_pull,
  output logic stretch_timeout
);
  localparam int TMAX = (CLK_HZ / 1_000_000) * STRETCH_US;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DMAX = (DLY_SLOW > DLY_FAST) ? DLY_SLOW : DLY_FAST;
  localparam int DW   = $clog2(DMAX + 2);

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  logic          in_xfer, at_start, win, hold, rate_q;
  logic [3:0]    bitcnt;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] tcnt;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire legal    = in_xfer & scl_fall & (at_start | (bitcnt == 4'd9));
  wire [DW-1:0] dly = rate_q ? DW'(DLY_FAST) : DW'(DLY_SLOW);

  assign scl_pull = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11;
      scl_d  <= 1'b1;  sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer <= 1'b0; at_start <= 1'b0; bitcnt <= '0;
      win <= 1'b0; hold <= 1'b0; dcnt <= '0; tcnt <= '0;
      rate_q <= 1'b0; stretch_timeout <= 1'b0;
    end else begin
      stretch_timeout <= 1'b0;
      if (!in_xfer) rate_q <= rate_fast;
      if (start_c) begin
        in_xfer <= 1'b1; at_start <= 1'b1; bitcnt <= '0;
        win <= 1'b0; hold <= 1'b0;
      end else if (stop_c) begin
        in_xfer <= 1'b0; at_start <= 1'b0; bitcnt <= '0;
        win <= 1'b0; hold <= 1'b0;
      end else begin
        if (in_xfer && scl_rise && !at_start) bitcnt <= bitcnt + 4'd1;
        if (hold) begin
          if (!busy) begin
            hold <= 1'b0; win <= 1'b0;
          end else if (tcnt == TW'(TMAX - 1)) begin
            hold <= 1'b0; win <= 1'b0; stretch_timeout <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end else if (legal) begin
          win <= 1'b1; dcnt <= '0;
        end else if (win) begin
          if (scl_rise) win <= 1'b0;
          else if (busy && dcnt >= dly) begin
            hold <= 1'b1; tcnt <= '0;
          end else if (dcnt < dly) dcnt <= dcnt + 1'b1;
        end
        if (legal) begin
          at_start <= 1'b0; bitcnt <= '0;
        end
      end
    end
  end
endmodule

module i2c_stretch_ctrl_chk #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int STRETCH_US = 25_000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic scl_s,
  input logic scl_pull,
  input logic stretch_timeout
);
  localparam int TMAX = (CLK_HZ / 1_000_000) * STRETCH_US;
  int run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else run <= scl_pull ? run + 1 : 0;

  AST_PULL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> $past(busy)); // R3
  AST_PULL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> $past(!scl_s)); // R2
  AST_TOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_timeout |=> !stretch_timeout); // R5
  AST_TOUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_timeout |-> (!scl_pull && $past(scl_pull))); // R5
  AST_NO_RESTRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |=> !scl_pull); // R6
  AST_STRETCH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    run <= TMAX); // R5
endmodule

bind i2c_stretch_ctrl i2c_stretch_ctrl_chk #(.CLK_HZ(CLK_HZ), .STRETCH_US(STRETCH_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .scl_s(scl_s),
  .scl_pull(scl_pull), .stretch_timeout(stretch_timeout)
);

// File: tb/i2c_stretch_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_stretch_ctrl_bench;
  localparam int CLK_HZ = 1_000_000;
  localparam int US     = 300;
  localparam int TMAX   = (CLK_HZ / 1_000_000) * US;
  localparam int DS     = 12;
  localparam int DF     = 3;
  localparam int H      = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0, rate_fast = 1'b0;
  logic scl_pull, stretch_timeout;
  wire  scl_bus = scl_m & ~scl_pull;
  int checks = 0, failures = 0, pull_cnt = 0;

  always #5 clk = ~clk;
  always @(negedge clk) if (scl_pull) pull_cnt++;

  i2c_stretch_ctrl #(.CLK_HZ(CLK_HZ), .STRETCH_US(US), .DLY_SLOW(DS), .DLY_FAST(DF)) u_i2c_stretch_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_m), .busy(busy),
    .rate_fast(rate_fast), .scl_pull(scl_pull), .stretch_timeout(stretch_timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_high();
    while (!scl_bus) tick(1);
  endtask
  task automatic do_start();
    sda_m = 1; scl_m = 1; wait_high(); tick(H); sda_m = 0; tick(H); scl_m = 0;
  endtask
  task automatic do_rstart();
    sda_m = 1; tick(H); scl_m = 1; wait_high(); tick(H); sda_m = 0; tick(H); scl_m = 0;
  endtask
  task automatic do_stop();
    sda_m = 0; tick(H); scl_m = 1; wait_high(); tick(H); sda_m = 1; tick(H);
  endtask
  task automatic do_bit(input logic b);
    sda_m = b; tick(H); scl_m = 1; wait_high(); tick(H); scl_m = 0;
  endtask
  task automatic pull_due(input int d, input string req);
    tick(d + 3); chk(scl_pull == 1'b0, req, scl_pull, 0);
    tick(1);     chk(scl_pull == 1'b1, req, scl_pull, 1);
  endtask

  task automatic t_reset();
    chk(scl_pull == 0 && stretch_timeout == 0, "R1 in reset", {scl_pull, stretch_timeout}, 0);
    rst_n = 1; tick(1);
    chk(scl_pull == 0 && stretch_timeout == 0, "R1 after reset", {scl_pull, stretch_timeout}, 0);
  endtask

  task automatic t_ack_stretch();
    busy = 0; do_start(); do_bit(1); busy = 1; pull_cnt = 0;
    for (int i = 0; i < 7; i++) do_bit(i[0]);
    chk(pull_cnt == 0, "R2 bits 1-8", pull_cnt, 0);
    do_bit(0);
    pull_due(DS, "R7 slow delay after ninth clock");
    tick(50); chk(scl_pull == 1'b1, "R3 held while busy", scl_pull, 1);
    busy = 0; tick(1);
    chk(scl_pull == 1'b0, "R3 release on busy low", scl_pull, 0);
    do_stop();
  endtask

  task automatic t_rate();
    rate_fast = 1; tick(3); busy = 1; do_start();
    pull_due(DF, "R4 R8 fast stretch at START");
    busy = 0; tick(1);
    do_bit(1); rate_fast = 0; busy = 1;
    for (int i = 0; i < 7; i++) do_bit(1);
    do_bit(0);
    pull_due(DF, "R8 rate kept during transfer");
    busy = 0; tick(1); do_stop();
    tick(3); busy = 1; do_start();
    pull_due(DS, "R8 slow rate taken after STOP");
    busy = 0; tick(1); do_stop();
  endtask

  task automatic t_timeout();
    busy = 0; do_start(); do_bit(0); busy = 1;
    for (int i = 0; i < 7; i++) do_bit(0);
    do_bit(0);
    tick(DS + 4);
    chk(scl_pull == 1'b1, "R5 stretch started", scl_pull, 1);
    tick(TMAX - 1);
    chk(scl_pull == 1'b1 && stretch_timeout == 0, "R5 held up to cap", {scl_pull, stretch_timeout}, 2);
    tick(1);
    chk(scl_pull == 1'b0 && stretch_timeout == 1, "R5 released at cap", {scl_pull, stretch_timeout}, 1);
    tick(1);
    chk(stretch_timeout == 1'b0, "R5 one-cycle pulse", stretch_timeout, 0);
    pull_cnt = 0; tick(20);
    chk(pull_cnt == 0, "R6 no restretch in same phase", pull_cnt, 0);
    do_bit(1);
    chk(pull_cnt == 0, "R6 no restretch on next bit", pull_cnt, 0);
    busy = 0; do_stop();
  endtask

  task automatic t_cancel();
    busy = 0; do_start();
    for (int i = 0; i < 4; i++) do_bit(1);
    do_rstart(); do_bit(1); busy = 1; pull_cnt = 0;
    for (int i = 0; i < 7; i++) do_bit(0);
    chk(pull_cnt == 0, "R9 count cleared by repeated START", pull_cnt, 0);
    do_bit(0);
    pull_due(DS, "R9 ninth clock after repeated START");
    busy = 0; tick(1); do_stop();
    busy = 1; pull_cnt = 0; tick(60);
    chk(pull_cnt == 0, "R9 no stretch after STOP", pull_cnt, 0);
    busy = 0;
  endtask

  initial begin
    tick(5);
    t_reset();
    tick(10);
    t_ack_stretch();
    t_rate();
    t_timeout();
    t_cancel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule